// File: doc/BRIEF.md
# Half-Band Decimate-by-Two FIR Stage

This block is one stage of a sample-rate reducer. Input samples arrive on a valid/data pair at the high rate. The stage emits one low-pass filtered sample for every two it accepts. Three stages with the same interface can be chained to reduce the rate by eight.

The filter is a half-band FIR with 4*NP-1 taps (15 by default). Its non-zero taps are a centre coefficient and NP symmetric pairs at odd offsets from the centre. Every tap at an even non-zero offset is zero and costs no arithmetic. The stage stores incoming samples in two polyphase branches, chosen by the parity of the input. A bank of pre-adders sums the two samples that share each pair coefficient. A single multiplier then steps through the NP folded pairs and the centre sample, one product per clock. The sum is rounded, saturated and presented with a one-clock valid pulse. All coefficients are fixed by parameters.

The upstream source must leave at least NP+2 clocks between an accepted input that starts a computation and the next input. An input that arrives earlier is flagged.

Top module: `hb_decim2`

## Requirements
- R1: After reset, an output is produced on the 15th accepted input (4*NP-1 in general) and then on every second accepted input (17th, 19th, ...). No output is produced on any other input.
- R2: With n the newest accepted sample and x[n-k] the sample k inputs older, the output is the sum of h[k]*x[n-k] for k = 0..14. The centre tap is h[7] = CENTRE_COEF. The taps h[7-(2j+1)] and h[7+(2j+1)] both use pair coefficient j, taken from PAIR_COEFS bits [j*CW +: CW]. All other taps are zero. Coefficients are signed fractions with CW-1 fraction bits.
- R3: The full-precision sum is scaled by 2^-(CW-1) with round-half-up, giving floor((acc + 2^(CW-2)) / 2^(CW-1)). For example, +1.5 becomes 2 and -1.5 becomes -1.
- R4: A scaled result outside the signed DW-bit range is clamped to 2^(DW-1)-1 or to -2^(DW-1).
- R5: out_valid is high for exactly one clock, NP+1 clocks after the edge that accepted the triggering input. out_data keeps its value between pulses.
- R6: in_valid high while a computation is running sets overrun. A computation runs during the NP+1 clock edges after a triggering input is accepted. overrun then stays high until reset. Inputs spaced NP+2 or more clocks apart never set it.
- R7: A clock edge with rst_n low clears out_valid, out_data and overrun, and empties the sample history. After release, outputs depend only on samples accepted afterwards, with the first output again on the 15th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-clock output strobe |
| out_data | output | DW | Signed filtered, decimated sample |
| overrun | output | 1 | Sticky flag: input arrived during a computation |

## Verification
On every cycle, the checker enforces the following: the output strobe is a single-cycle pulse that only follows a busy interval; that interval never exceeds NP+1 clocks; out_data is held between strobes; the overrun flag is sticky and is raised only by an input that lands during a computation; and reset clears the outputs. The numerical behaviour can only be shown by the bench's scenarios, which compare against an independent tap-by-tap model. That behaviour covers tap placement, folding, the exact round-half-up point, saturation at both rails, the 15-sample fill, decimation phase, output latency, and history loss across a reset.

// File: rtl/hb_pkg.sv
// Shared definitions for the half-band decimator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hb_pkg;
    typedef enum logic {
        MAC_IDLE = 1'b0,
        MAC_RUN  = 1'b1
    } mac_state_e;

    // Number of taps of a half-band filter with np symmetric odd-offset pairs.
    function automatic int hb_taps(input int np);
        return 4 * np - 1;
    endfunction
endpackage

// File: rtl/hb_polyphase_line.sv
// Polyphase sample store. Even-parity inputs (those that may trigger an
// output) shift into the even branch. Odd-parity inputs shift into the odd
// branch. Also tracks the input phase and the fill level, and raises
// trigger when the accepted sample completes a full window.
// Assumes: push is one clock wide per accepted sample.
module hb_polyphase_line #(
    parameter int DW = 16,
    parameter int NP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [DW-1:0] din,
    output logic [2*NP*DW-1:0]   even_flat,
    output logic signed [DW-1:0] centre_smp,
    output logic                 trigger
);
    localparam int NE   = 2 * NP;
    localparam int TAPS = hb_pkg::hb_taps(NP);
    localparam int FW   = $clog2(TAPS + 1);

    logic          phase;
    logic [FW-1:0] fill;
    logic signed [DW-1:0] ev [NE];
    logic signed [DW-1:0] od [NP];

    // Input phase toggle and saturating fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            fill  <= '0;
        end else if (push) begin
            phase <= ~phase;
            if (fill != FW'(TAPS)) fill <= fill + FW'(1);
        end
    end

    // Even branch shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) ev[i] <= '0;
        end else if (push && !phase) begin
            for (int i = NE - 1; i > 0; i--) ev[i] <= ev[i-1];
            ev[0] <= din;
        end
    end

    // Odd branch shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) od[i] <= '0;
        end else if (push && phase) begin
            for (int i = NP - 1; i > 0; i--) od[i] <= od[i-1];
            od[0] <= din;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NE; g++) begin : g_flat
            assign even_flat[g*DW +: DW] = ev[g];
        end
    endgenerate

    assign centre_smp = od[NP-1];
    assign trigger    = push && !phase && (fill >= FW'(TAPS - 1));
endmodule

// File: rtl/hb_fold.sv
// Symmetry pre-adders. Pair j sums the two even-branch samples that sit at
// offsets +/-(2j+1) from the centre tap.
// Assumes: even_flat element 0 holds the newest even-parity sample.
module hb_fold #(
    parameter int DW = 16,
    parameter int NP = 4
) (
    input  logic [2*NP*DW-1:0]     even_flat,
    output logic [NP*(DW+1)-1:0]   sums_flat
);
    localparam int SW = DW + 1;

    genvar j;
    generate
        for (j = 0; j < NP; j++) begin : g_pair
            logic signed [DW-1:0] near_s, far_s;
            assign near_s = $signed(even_flat[(NP-1-j)*DW +: DW]);
            assign far_s  = $signed(even_flat[(NP+j)*DW +: DW]);
            assign sums_flat[j*SW +: SW] = SW'(near_s) + SW'(far_s);
        end
    endgenerate
endmodule

// File: rtl/hb_seq_mac.sv
// Time-shared multiply-accumulate. On start it takes NP+1 clocks. Steps
// 0..NP-1 multiply the folded pairs and step NP multiplies the centre
// sample. At the last step it rounds half up, saturates and pulses out_valid.
// Assumes: start only arrives while idle; its operands stay stable while busy.
module hb_seq_mac #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int NP = 4,
    parameter logic signed [CW-1:0] CENTRE_COEF = 16'sd16384,
    parameter logic [NP*CW-1:0]     PAIR_COEFS  = 64'hFEB0_0484_F4D4_26A4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NP*(DW+1)-1:0]   sums_flat,
    input  logic signed [DW-1:0]   centre_in,
    output logic                   busy,
    output logic                   out_valid,
    output logic signed [DW-1:0]   out_data
);
    import hb_pkg::*;

    localparam int SW    = DW + 1;
    localparam int PW    = SW + CW;
    localparam int STW   = $clog2(NP + 1);
    localparam int ACC_W = PW + STW;
    localparam int FRAC  = CW - 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DW - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

    mac_state_e state;
    logic [STW-1:0]          step;
    logic signed [ACC_W-1:0] acc, acc_nxt, scaled;
    logic signed [SW-1:0]    opd_arr [NP+1];
    logic signed [CW-1:0]    cf_arr  [NP+1];
    logic signed [PW-1:0]    prod;
    logic signed [DW-1:0]    sat_val;

    genvar j;
    generate
        for (j = 0; j < NP; j++) begin : g_ops
            assign opd_arr[j] = $signed(sums_flat[j*SW +: SW]);
            assign cf_arr[j]  = $signed(PAIR_COEFS[j*CW +: CW]);
        end
    endgenerate
    assign opd_arr[NP] = SW'(centre_in);
    assign cf_arr[NP]  = CENTRE_COEF;

    // Product of the current step and the running sum.
    always_comb begin
        prod    = PW'(opd_arr[step]) * PW'(cf_arr[step]);
        acc_nxt = acc + ACC_W'(prod);
    end

    // Round half up, then clamp to the signed output range.
    always_comb begin
        scaled = (acc_nxt + HALF) >>> FRAC;
        if (scaled > MAXV)      sat_val = MAXV[DW-1:0];
        else if (scaled < MINV) sat_val = MINV[DW-1:0];
        else                    sat_val = scaled[DW-1:0];
    end

    // Step sequencer, accumulator and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MAC_IDLE;
            step      <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                MAC_IDLE: begin
                    if (start) begin
                        state <= MAC_RUN;
                        step  <= '0;
                        acc   <= '0;
                    end
                end
                default: begin
                    if (step == STW'(NP)) begin
                        out_data  <= sat_val;
                        out_valid <= 1'b1;
                        acc       <= '0;
                        step      <= '0;
                        state     <= MAC_IDLE;
                    end else begin
                        acc  <= acc_nxt;
                        step <= step + STW'(1);
                    end
                end
            endcase
        end
    end

    assign busy = (state == MAC_RUN);
endmodule

// File: rtl/hb_decim2.sv
// Half-band decimate-by-two stage: polyphase store, symmetry pre-adders and
// one sequential MAC running at the output rate. Raises a sticky overrun
// flag if an input arrives while a computation is running. That input is
// dropped.
// Assumes: inputs to a triggering sample are spaced at least NP+2 clocks apart.
module hb_decim2 #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int NP = 4,
    parameter logic signed [CW-1:0] CENTRE_COEF = 16'sd16384,
    parameter logic [NP*CW-1:0]     PAIR_COEFS  = 64'hFEB0_0484_F4D4_26A4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 overrun
);
    logic                   busy, push, trigger;
    logic [2*NP*DW-1:0]     even_flat;
    logic [NP*(DW+1)-1:0]   sums_flat;
    logic signed [DW-1:0]   centre_smp;

    assign push = in_valid && !busy;

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (in_valid && busy) overrun <= 1'b1;
    end

    hb_polyphase_line #(.DW(DW), .NP(NP)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .din        (in_data),
        .even_flat  (even_flat),
        .centre_smp (centre_smp),
        .trigger    (trigger)
    );

    hb_fold #(.DW(DW), .NP(NP)) u_fold (
        .even_flat (even_flat),
        .sums_flat (sums_flat)
    );

    hb_seq_mac #(
        .DW(DW), .CW(CW), .NP(NP),
        .CENTRE_COEF(CENTRE_COEF), .PAIR_COEFS(PAIR_COEFS)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (trigger),
        .sums_flat (sums_flat),
        .centre_in (centre_smp),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/hb_decim2_chk.sv
// Protocol checker for hb_decim2, attached by bind.
// Assumes: reset is synchronous and active low.
module hb_decim2_chk #(
    parameter int DW = 16,
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          busy,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          overrun
);
    logic armed;
    int   run_len;

    // Arm the $past-based checks one clock after reset release.
    always_ff @(posedge clk) armed <= rst_n;

    // Measure the length of each busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else run_len <= 0;
    end

    // R5: computation never exceeds NP+1 clocks.
    always_ff @(posedge clk) begin
        if (rst_n) p_busy_len_r5: assert (run_len <= NP + 1)
            else $error("busy interval too long");
    end

    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !out_valid |-> $stable(out_data));

    p_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid |-> $past(busy));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(overrun) |-> $past(in_valid && busy));

    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overrun && out_data == '0));
endmodule

bind hb_decim2 hb_decim2_chk #(.DW(DW), .NP(NP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (overrun)
);

// File: tb/hb_decim2_tb.sv
// Self-checking bench: directed rounding, saturation, overrun and reset
// cases plus seeded random streams, compared with a tap-by-tap model.
module hb_decim2_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic signed [15:0] out_data;
    logic overrun;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int hist [0:2047];
    int hn = 0;
    int exp_q[$];
    int cyc_q[$];
    int last_out = 0;
    int n_out = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hb_decim2 u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    function automatic int coef(int k);
        int d, a;
        int pairs [4] = '{9892, -2860, 1156, -336};
        d = k - 7;
        a = (d < 0) ? -d : d;
        if (d == 0) return 16384;
        if (a % 2 == 1) return pairs[(a - 1) / 2];
        return 0;
    endfunction

    // R2/R3/R4 model: weighted window, round half up, clamp.
    function automatic int model(int n);
        longint acc = 0;
        longint r;
        for (int k = 0; k < 15; k++) acc += longint'(coef(k)) * longint'(hist[n-k]);
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic send(int v, int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(v);
        @(negedge clk);
        in_valid = 1'b0;
        hist[hn] = v;
        hn++;
        if (hn >= 15 && (hn % 2) == 1) begin   // R1 trigger positions
            exp_q.push_back(model(hn - 1));
            cyc_q.push_back(cyc);
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 out_valid in reset", int'(out_valid), 0);
        check("R7 out_data in reset", int'(out_data), 0);
        check("R7 overrun in reset", int'(overrun), 0);
        @(negedge clk);
        rst_n = 1'b1;
        hn = 0;
        exp_q.delete();
        cyc_q.delete();
        n_out = 0;
    endtask

    // Output monitor: value (R2..R4), latency (R5), position (R1).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            last_out = int'(out_data);
            if (exp_q.size() == 0) begin
                check("R1 unexpected output", 1, 0);
            end else begin
                check("R2 output value", int'(out_data), exp_q.pop_front());
                check("R5 latency", cyc - cyc_q.pop_front(), 5);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int pat [15] = '{-1, 0, 1, 0, -1, 0, 1, 1, 1, 0, -1, 0, 1, 0, -1};
        seed_dummy = $urandom(32'd20240611);

        do_reset();

        // R3: centre-only window of +3 -> 1.5 rounds up to 2.
        for (int i = 0; i < 15; i++) send((i == 7) ? 3 : 0, 5);
        repeat (10) @(negedge clk);
        check("R3 +1.5 rounds up", last_out, 2);
        check("R1 single output after 15 inputs", n_out, 1);

        // R3: -1.5 rounds up to -1.
        do_reset();
        for (int i = 0; i < 15; i++) send((i == 7) ? -3 : 0, 5);
        repeat (10) @(negedge clk);
        check("R3 -1.5 rounds up", last_out, -1);

        // R4: sign-matched full-scale window saturates positive, then negative.
        do_reset();
        for (int i = 0; i < 15; i++) send(pat[i] * 32767, 5);
        repeat (10) @(negedge clk);
        check("R4 positive clamp", last_out, 32767);
        do_reset();
        for (int i = 0; i < 15; i++) send(-pat[i] * 32767, 5);
        repeat (10) @(negedge clk);
        check("R4 negative clamp", last_out, -32768);

        // R1/R2: 14 inputs give no output.
        do_reset();
        for (int i = 0; i < 14; i++) send(1000 + i, 5);
        repeat (10) @(negedge clk);
        check("R1 no output before fill", n_out, 0);

        // Random stream with mixed gaps.
        for (int i = 0; i < 200; i++) send(int'($urandom % 65536) - 32768, 5 + int'($urandom % 3));
        repeat (10) @(negedge clk);
        check("R1 all expected outputs seen", exp_q.size(), 0);
        check("R6 no overrun with legal spacing", int'(overrun), 0);

        // R7: mid-stream reset discards history.
        do_reset();
        for (int i = 0; i < 200; i++) send(int'($urandom % 2001) - 1000, 5 + int'($urandom % 2));
        repeat (10) @(negedge clk);
        check("R7 outputs after reset match fresh history", exp_q.size(), 0);
        check("R1 output count after reset", n_out, 93);

        // R6: input one clock after a triggering input sets overrun.
        do_reset();
        for (int i = 0; i < 14; i++) send(i * 50, 5);
        send(700, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'sd5;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R6 overrun raised", int'(overrun), 1);
        check("R6 trigger output still produced", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        check("R6 overrun sticky", int'(overrun), 1);
        do_reset();
        @(negedge clk);
        check("R7 overrun cleared by reset", int'(overrun), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule